// File: doc/BRIEF.md
# I2C Slave Byte Port Engine

This block is the bus-facing half of a register port that answers as a target on a two-wire I2C bus and never starts a transfer itself. A fast system clock samples SCL and SDA through synchronizers, and the bus edges, START and STOP are all recovered from those samples. The first byte after a START carries a 7-bit device address and a direction bit. The address has a fixed five-bit prefix plus two bits taken from strap pins. On a match the engine pulls SDA low for the acknowledge clock. On a mismatch it leaves the bus alone until the next START.

Toward the register layer the engine offers two single-cycle byte strobes. When a written byte is complete, the engine presents it for one cycle and samples a same-cycle accept flag. A refused byte is answered with a NACK and ends the transfer. For a master read, the engine asks for a transmit byte in the same cycle it recognises the read address. It asks again each time the master acknowledges a byte. SDA is open-drain: the block only ever drives it low, and it changes that drive only while SCL is low. A START seen anywhere in a transfer abandons any partial byte and begins a new address phase. A STOP seen anywhere sends the engine to idle.

Top module: `i2cs_port`

## Requirements
- R1: After reset, sda_oe, rx_valid and tx_req are all 0.
- R2: The address byte is shifted MSB first and reads 0,1,1,0,1,addr_pin_hi,addr_pin_lo,R/W (R/W 0 = master write, 1 = master read), so full bytes span 0x68 to 0x6F. On a match the engine holds sda_oe at 1 through the ninth SCL high period.
- R3: On an address mismatch no acknowledge is driven. Until the next START, later bytes produce no rx_valid and no acknowledge.
- R4: Each byte written after a matching write address is presented MSB first on rx_data with a one-cycle rx_valid. rx_first is 1 only for the first data byte after an address match.
- R5: When rx_accept is 1 in the rx_valid cycle, the byte is acknowledged. When it is 0, the ninth clock sees SDA released, and nothing further is received or acknowledged until the next START.
- R6: On a matching read address, tx_req pulses for one cycle and tx_data is taken in that cycle. The byte is sent MSB first, and SDA changes only while SCL is low.
- R7: A master acknowledge (SDA low on the ninth clock) after a sent byte causes the next tx_req and the next byte. A master NACK ends the read: SDA stays released and tx_req stays 0.
- R8: A repeated START after a write address and a subaddress byte, followed by the read address, starts a read without an intervening STOP.
- R9: A STOP at any point returns the engine to idle with SDA released, and bytes clocked afterwards without a START are ignored. A START in the middle of a data byte discards the partial byte with no rx_valid and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pin_hi | input | 1 | Strap for 7-bit address bit 1 (byte bit 2) |
| addr_pin_lo | input | 1 | Strap for 7-bit address bit 0 (byte bit 1) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte, valid with rx_valid |
| rx_first | output | 1 | Marks the first data byte after the address |
| rx_accept | input | 1 | Register layer accepts the byte (sampled with rx_valid) |
| tx_req | output | 1 | One-cycle request for the next transmit byte |
| tx_data | input | 8 | Transmit byte, sampled with tx_req |

## Verification
The address decoder is tried with the straps at 00, 11 and 10. The 10 setting is paired with the byte whose strap bits are swapped, which shows that each strap reaches its own bit position and that the direction bit is not part of the compare. Write traffic mixes accepted bytes with one refused byte, so a NACK that really halts the transfer can be told apart from one that only drops a single byte. Reads use a repeated START and end with a master NACK, which separates prefetch-on-acknowledge from fetching on every byte. STOP and START are also placed mid-transfer, to show that partial bytes are discarded and that idle really ignores clocked bytes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [4:0] DEV_PREFIX = 5'b01101;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_SACK,
        ST_SEND,
        ST_MACK
    } state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic hi, input logic lo);
        return a == {DEV_PREFIX, hi, lo};
    endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_line_events.sv
module i2cs_line_events
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (raw[i]),
            .q  (cur[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    always_comb begin
        ev.sda      = cur[1];
        ev.scl_rise = cur[0] & ~prev[0];
        ev.scl_fall = ~cur[0] & prev[0];
        ev.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
        ev.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
    end
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        addr_pin_hi,
    input  logic        addr_pin_lo,
    output logic        sda_oe,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        rx_first,
    input  logic        rx_accept,
    output logic        tx_req,
    input  logic [7:0]  tx_data
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_ev_t          ev;
    state_t           state;
    logic [CNT_W-1:0] cnt;
    byte_t            sh;
    logic             is_addr;
    logic             rw;
    logic             first;
    logic             phase;
    logic             byte_done;
    logic             hit;

    i2cs_line_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev   (ev)
    );

    assign byte_done = (state == ST_RECV) && ev.scl_rise && (cnt == LAST_BIT) && !ev.start && !ev.stop;
    assign hit       = addr_hit(sh[6:0], addr_pin_hi, addr_pin_lo);
    assign rx_data   = {sh[6:0], ev.sda};
    assign rx_valid  = byte_done && !is_addr;
    assign rx_first  = first;
    assign tx_req    = (byte_done && is_addr && hit && ev.sda)
                     || ((state == ST_MACK) && ev.scl_rise && !ev.sda && !phase && !ev.start && !ev.stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            is_addr <= 1'b0;
            rw      <= 1'b0;
            first   <= 1'b0;
            phase   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_RECV;
            is_addr <= 1'b1;
            cnt     <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_RECV: begin
                    if (ev.scl_rise) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            phase <= 1'b0;
                            if (is_addr) begin
                                if (hit) begin
                                    rw    <= ev.sda;
                                    first <= 1'b1;
                                    state <= ST_SACK;
                                    if (ev.sda) sh <= tx_data;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                first <= 1'b0;
                                state <= rx_accept ? ST_SACK : ST_IDLE;
                            end
                        end
                    end
                end
                ST_SACK: begin
                    if (ev.scl_fall) begin
                        if (!phase) begin
                            sda_oe <= 1'b1;
                            phase  <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            cnt   <= '0;
                            if (rw) begin
                                state  <= ST_SEND;
                                sda_oe <= ~sh[7];
                            end else begin
                                state   <= ST_RECV;
                                is_addr <= 1'b0;
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                end
                ST_SEND: begin
                    if (ev.scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            phase  <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise && !phase) begin
                        if (!ev.sda) begin
                            sh    <= tx_data;
                            phase <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (ev.scl_fall && phase) begin
                        phase  <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_SEND;
                        sda_oe <= ~sh[7];
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2cs_port_chk.sv
module i2cs_port_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe,
    input logic rx_valid,
    input logic tx_req
);
    // R6: the SDA drive only moves while the bus clock is low
    a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    // R4: a received byte is a single-cycle strobe
    a_r4_rx_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: bytes complete on a clock high phase
    a_r4_rx_on_scl_high: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> scl_i);

    // R7: each transmit request is a single-cycle strobe
    a_r7_tx_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);

    // R6: receive and transmit strobes never coincide
    a_r6_tx_not_with_rx: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && tx_req));
endmodule

bind i2cs_port i2cs_port_chk u_chk (.*);

// File: tb/tb_i2cs_port.sv
module tb_i2cs_port;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       pin_hi = 1'b0;
    logic       pin_lo = 1'b0;
    logic       sda_oe, rx_valid, rx_first, rx_accept, tx_req;
    logic [7:0] rx_data, tx_data;
    logic       sda_bus;

    logic [7:0] tx_mem [0:3];
    int         tx_idx = 0;
    logic [7:0] rx_log [0:31];
    logic       rx_fl  [0:31];
    int         rx_n = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         hi_glitch = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    assign sda_bus   = msda & ~sda_oe;
    assign rx_accept = (rx_data != 8'hEE);
    assign tx_data   = tx_mem[tx_idx[1:0]];

    i2cs_port dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .addr_pin_hi(pin_hi), .addr_pin_lo(pin_lo),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_first(rx_first), .rx_accept(rx_accept),
        .tx_req(tx_req), .tx_data(tx_data)
    );

    always @(posedge clk) begin
        if (rx_valid && rx_n < 32) begin
            rx_log[rx_n] <= rx_data;
            rx_fl[rx_n]  <= rx_first;
            rx_n         <= rx_n + 1;
        end
        if (tx_req) tx_idx <= tx_idx + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic do_stop();
        msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw();
    endtask

    task automatic bit_out(input logic b);
        msda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        msda = 1'b1; qw(); scl = 1'b1; qw();
        ack = ~sda_bus;
        qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; qw(); scl = 1'b1;
            repeat (2) @(negedge clk);
            b[i] = sda_bus;
            repeat (2 * Q - 4) @(negedge clk);
            if (sda_bus != b[i]) hi_glitch++;
            repeat (2) @(negedge clk);
            scl = 1'b0; qw();
        end
        bit_out(~mack);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 tx_req", tx_req, 0);
    endtask

    task automatic t_write();
        logic a;
        int n0;
        n0 = rx_n;
        pin_hi = 0; pin_lo = 0;
        do_start();
        send_byte(8'h68, a); chk("R2 ack 0x68", a, 1);
        send_byte(8'h12, a); chk("R5 ack 0x12", a, 1);
        send_byte(8'hA5, a); chk("R5 ack 0xA5", a, 1);
        do_stop();
        chk("R4 rx count", rx_n - n0, 2);
        chk("R4 byte0", rx_log[n0], 8'h12);
        chk("R4 byte1", rx_log[n0+1], 8'hA5);
        chk("R4 first0", rx_fl[n0], 1);
        chk("R4 first1", rx_fl[n0+1], 0);
        chk("R9 oe after stop", sda_oe, 0);
    endtask

    task automatic t_addr();
        logic a;
        int n0;
        pin_hi = 1; pin_lo = 1;
        do_start(); send_byte(8'h6E, a); chk("R2 straps 11", a, 1); do_stop();
        n0 = rx_n;
        do_start(); send_byte(8'h68, a); chk("R3 nack 0x68", a, 0);
        send_byte(8'h55, a); chk("R3 no ack data", a, 0); do_stop();
        chk("R3 no rx", rx_n - n0, 0);
        pin_hi = 1; pin_lo = 0;
        do_start(); send_byte(8'h6C, a); chk("R2 straps 10", a, 1); do_stop();
        do_start(); send_byte(8'h6A, a); chk("R2 swapped straps", a, 0); do_stop();
        pin_hi = 0; pin_lo = 0;
    endtask

    task automatic t_reject();
        logic a;
        int n0;
        n0 = rx_n;
        do_start();
        send_byte(8'h68, a);
        send_byte(8'h33, a); chk("R5 accept ack", a, 1);
        send_byte(8'hEE, a); chk("R5 reject nack", a, 0);
        send_byte(8'h44, a); chk("R5 ignored after reject", a, 0);
        do_stop();
        chk("R5 rx count", rx_n - n0, 2);
        chk("R5 last rx", rx_log[n0+1], 8'hEE);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        tx_mem[0] = 8'hC3; tx_mem[1] = 8'h5A; tx_mem[2] = 8'h81; tx_mem[3] = 8'h00;
        tx_idx = 0;
        hi_glitch = 0;
        do_start();
        send_byte(8'h68, a);
        send_byte(8'h07, a); chk("R8 subaddr ack", a, 1);
        do_start();
        send_byte(8'h69, a); chk("R8 read addr ack", a, 1);
        chk("R6 first tx_req", tx_idx, 1);
        recv_byte(b, 1); chk("R6 byte0", b, 8'hC3);
        recv_byte(b, 1); chk("R7 byte1", b, 8'h5A);
        recv_byte(b, 0); chk("R7 byte2", b, 8'h81);
        chk("R7 oe released", sda_oe, 0);
        recv_byte(b, 0); chk("R7 bus idle after nack", b, 8'hFF);
        chk("R7 req count", tx_idx, 3);
        chk("R6 sda stable scl high", hi_glitch, 0);
        do_stop();
    endtask

    task automatic t_mid_start();
        logic a;
        int n0;
        n0 = rx_n;
        do_start();
        send_byte(8'h68, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        do_start();
        send_byte(8'h68, a); chk("R9 addr after mid start", a, 1);
        send_byte(8'h77, a);
        do_stop();
        chk("R9 partial dropped", rx_n - n0, 1);
        chk("R9 new byte", rx_log[n0], 8'h77);
        chk("R9 new first", rx_fl[n0], 1);
    endtask

    task automatic t_mid_stop();
        logic a;
        int n0;
        n0 = rx_n;
        do_start();
        send_byte(8'h68, a);
        send_byte(8'h10, a);
        do_stop();
        chk("R9 oe after stop", sda_oe, 0);
        scl = 1'b0; qw();
        send_byte(8'h20, a); chk("R9 no ack idle", a, 0);
        msda = 1'b1; qw(); scl = 1'b1; qw();
        chk("R9 rx count", rx_n - n0, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_addr();
        t_reject();
        t_read();
        t_mid_start();
        t_mid_stop();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule